// File: doc/BRIEF.md
# Granule Tag Checker for Nibble-Packed Tag Memory

This block checks a memory access against the allocation tags that guard it. Memory is split into 16-byte granules, and each granule has a 4-bit tag. Tag memory stores two tags per byte. The access pointer carries its own 4-bit key. The checker reads the tag bytes that cover the accessed range and compares each granule's tag with the key, in address order. It stops at the first granule that does not match.

A command is the pointer, the access length minus one, and three qualifiers: a tag-check enable for each half of the address space, and a flag that says whether the page is tagged. The command is presented with a one-cycle `start`. While the command runs, `busy` is high and one tag byte is requested per cycle over a synchronous read port, whose data returns one cycle after the request. On completion, `done` pulses for one cycle. The `pass` and `fault_addr` outputs then keep their values until a later command replaces them.

There is no back-pressure on either side. A `start` seen while `busy` is high is dropped. The tag memory must return data exactly one cycle after `rd_en`.

Top module: `tagchk_top`

## Requirements
- R1: After reset, `busy`, `done`, `pass` and `rd_en` are 0 and `fault_addr` is 0.
- R2: If the tag-check enable for the pointer's half is 0, the command finishes with no tag read, and `done` is high in the cycle after `start`, with `pass`=1 and `fault_addr` equal to the pointer. Pointer bit 55 selects the half: 1 selects `chk_en_hi`, 0 selects `chk_en_lo`.
- R3: If `page_tagged` is 0, the command finishes in the same way as in R2 (no read, `pass`=1, `fault_addr`=pointer), whatever the tag memory holds.
- R4: A checked command reads tag bytes on consecutive cycles. The first read address is pointer bits [5+TADDR_W-1:5], which is the pointer shifted right by 5 and truncated. Each later read adds 1 to the address.
- R5: In a tag byte, bits [3:0] hold the tag of the even granule (address bit 4 = 0) and bits [7:4] hold the tag of the odd granule. A pointer with bit 4 set starts at the upper nibble.
- R6: The number of granules checked is ((ptr[3:0] + size_m1) >> 4) + 1. If all of them match, `pass`=1 and `fault_addr`=pointer.
- R7: If the first granule mismatches, `pass`=0 and `fault_addr` is the unmodified pointer.
- R8: If granule n>0 is the first to mismatch, `pass`=0 and `fault_addr` = {ptr[63:4] + n, 4'h0}.
- R9: The key compared against each granule tag is pointer bits [59:56].
- R10: `done` is a single-cycle pulse. `pass` and `fault_addr` stay unchanged while no `start` is accepted. A `start` while `busy` is high has no effect.
- R11: A `start` in the cycle where `done` is high is accepted as a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept a command (ignored while busy) |
| ptr | input | 64 | Access pointer, key in bits [59:56] |
| size_m1 | input | SIZE_W | Access length in bytes minus one |
| chk_en_lo | input | 1 | Tag check enable for pointers with bit 55 = 0 |
| chk_en_hi | input | 1 | Tag check enable for pointers with bit 55 = 1 |
| page_tagged | input | 1 | Page carries tags |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result: all granules matched or unchecked |
| fault_addr | output | 64 | Address of the first failing granule |
| rd_en | output | 1 | Tag memory read request |
| rd_addr | output | TADDR_W | Tag byte address |
| rd_data | input | 8 | Tag byte, valid one cycle after rd_en |

## Verification
Two events can land on the same clock edge: a command finishing and raising `done`, and the next command being accepted. The bench issues every new command in the cycle where it sees `done`, including unchecked commands whose own `done` follows in the very next cycle. A scoreboard then confirms that each completion reports its own command's result and its own first read address. A second case overlaps a stray `start` with a long command that is still busy, and the bench confirms that the result belongs to the original command.

// File: rtl/tagchk_pkg.sv
package tagchk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } tc_state_e;

  localparam int GRAN_LG = 4;            // 16-byte granule
  localparam int PAIR_LG = GRAN_LG + 1;  // two granules per tag byte
  localparam int KEY_LSB = 56;
endpackage

// File: rtl/tagchk_span.sv
module tagchk_span #(
  parameter int SIZE_W = 8,
  parameter int CNT_W  = SIZE_W - 2
) (
  input  logic [4:0]        ptr_lo,
  input  logic [SIZE_W-1:0] size_m1,
  output logic [CNT_W-1:0]  gran_cnt,
  output logic [CNT_W-1:0]  byte_cnt
);
  localparam int SUM_W = SIZE_W + 1;
  logic [SUM_W-1:0] end_g, end_b;

  assign end_g    = SUM_W'(ptr_lo[3:0]) + SUM_W'(size_m1);
  assign end_b    = SUM_W'(ptr_lo)      + SUM_W'(size_m1);
  assign gran_cnt = CNT_W'(end_g >> 4) + CNT_W'(1);
  assign byte_cnt = CNT_W'(end_b >> 5) + CNT_W'(1);
endmodule

// File: rtl/tagchk_nib.sv
module tagchk_nib (
  input  logic [7:0] tag_byte,
  input  logic [3:0] key,
  input  logic       odd,
  input  logic       two_left,
  output logic       lo_chk,
  output logic       hi_chk,
  output logic       lo_bad,
  output logic       hi_bad
);
  logic [7:0] diff;
  assign diff   = tag_byte ^ {key, key};
  assign lo_chk = !odd;
  assign hi_chk = odd || two_left;
  assign lo_bad = |diff[3:0];
  assign hi_bad = |diff[7:4];
endmodule

// File: rtl/tagchk_top.sv
module tagchk_top
  import tagchk_pkg::*;
#(
  parameter int SIZE_W  = 8,
  parameter int TADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [63:0]        ptr,
  input  logic [SIZE_W-1:0]  size_m1,
  input  logic               chk_en_lo,
  input  logic               chk_en_hi,
  input  logic               page_tagged,
  output logic               busy,
  output logic               done,
  output logic               pass,
  output logic [63:0]        fault_addr,
  output logic               rd_en,
  output logic [TADDR_W-1:0] rd_addr,
  input  logic [7:0]         rd_data
);
  localparam int CNT_W = SIZE_W - 2;

  tc_state_e        state;
  logic [63:0]      ptr_q;
  logic [3:0]       key_q;
  logic [CNT_W-1:0] gran_left, n_q, issue_left, issue_idx;
  logic             odd_q, pend_q, pass_q;
  logic [63:0]      fault_q;

  logic [CNT_W-1:0] gran_cnt, byte_cnt;
  logic             lo_chk, hi_chk, lo_bad, hi_bad;
  logic             accept, unchecked, two_left;
  logic [CNT_W-1:0] used, fail_n;

  tagchk_span #(.SIZE_W(SIZE_W), .CNT_W(CNT_W)) u_span (
    .ptr_lo(ptr[4:0]), .size_m1(size_m1),
    .gran_cnt(gran_cnt), .byte_cnt(byte_cnt)
  );

  assign two_left = gran_left > CNT_W'(1);

  tagchk_nib u_nib (
    .tag_byte(rd_data), .key(key_q), .odd(odd_q), .two_left(two_left),
    .lo_chk(lo_chk), .hi_chk(hi_chk), .lo_bad(lo_bad), .hi_bad(hi_bad)
  );

  assign accept    = start && (state != ST_RUN);
  assign unchecked = !(ptr[55] ? chk_en_hi : chk_en_lo) || !page_tagged;
  assign used      = CNT_W'(lo_chk) + CNT_W'(hi_chk);
  assign fail_n    = n_q + CNT_W'(lo_chk);

  assign busy       = (state == ST_RUN);
  assign done       = (state == ST_DONE);
  assign pass       = pass_q;
  assign fault_addr = fault_q;
  assign rd_en      = (state == ST_RUN) && (issue_left != '0);
  assign rd_addr    = ptr_q[PAIR_LG +: TADDR_W] + TADDR_W'(issue_idx);

  function automatic logic [63:0] gran_addr(input logic [63:0] p,
                                            input logic [CNT_W-1:0] n);
    if (n == '0) return p;
    return {p[63:GRAN_LG] + (64 - GRAN_LG)'(n), {GRAN_LG{1'b0}}};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      ptr_q      <= '0;
      key_q      <= '0;
      gran_left  <= '0;
      n_q        <= '0;
      issue_left <= '0;
      issue_idx  <= '0;
      odd_q      <= 1'b0;
      pend_q     <= 1'b0;
      pass_q     <= 1'b0;
      fault_q    <= '0;
    end else begin
      pend_q <= rd_en;
      if (accept) begin
        ptr_q      <= ptr;
        key_q      <= ptr[KEY_LSB +: 4];
        gran_left  <= gran_cnt;
        n_q        <= '0;
        issue_left <= byte_cnt;
        issue_idx  <= '0;
        odd_q      <= ptr[GRAN_LG];
        fault_q    <= ptr;
        if (unchecked) begin
          pass_q <= 1'b1;
          state  <= ST_DONE;
        end else begin
          pass_q <= 1'b0;
          state  <= ST_RUN;
        end
      end else begin
        case (state)
          ST_RUN: begin
            if (rd_en) begin
              issue_left <= issue_left - CNT_W'(1);
              issue_idx  <= issue_idx + CNT_W'(1);
            end
            if (pend_q) begin
              if (lo_chk && lo_bad) begin
                pass_q  <= 1'b0;
                fault_q <= gran_addr(ptr_q, n_q);
                state   <= ST_DONE;
              end else if (hi_chk && hi_bad) begin
                pass_q  <= 1'b0;
                fault_q <= gran_addr(ptr_q, fail_n);
                state   <= ST_DONE;
              end else if (gran_left == used) begin
                pass_q  <= 1'b1;
                fault_q <= ptr_q;
                state   <= ST_DONE;
              end else begin
                gran_left <= gran_left - used;
                n_q       <= n_q + used;
                odd_q     <= 1'b0;
              end
            end
          end
          ST_DONE: state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/tagchk_sva.sv
module tagchk_sva #(
  parameter int SIZE_W  = 8,
  parameter int TADDR_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [63:0]        ptr,
  input logic [SIZE_W-1:0]  size_m1,
  input logic               chk_en_lo,
  input logic               chk_en_hi,
  input logic               page_tagged,
  input logic               busy,
  input logic               done,
  input logic               pass,
  input logic [63:0]        fault_addr,
  input logic               rd_en,
  input logic [TADDR_W-1:0] rd_addr,
  input logic [7:0]         rd_data
);
  p_unchecked_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !(ptr[55] ? chk_en_hi : chk_en_lo)) |=> (done && pass && !rd_en));

  p_untagged_fast_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !page_tagged) |=> (done && pass && fault_addr == $past(ptr)));

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + TADDR_W'(1)));

  p_read_only_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_en);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(pass) && $stable(fault_addr)));

  p_no_double_role_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
endmodule

bind tagchk_top tagchk_sva #(.SIZE_W(SIZE_W), .TADDR_W(TADDR_W)) u_sva (.*);

// File: tb/sim_tagchk_top.sv
module sim_tagchk_top;
  localparam int SIZE_W = 8;
  localparam int TADDR_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [63:0] ptr = '0;
  logic [SIZE_W-1:0] size_m1 = '0;
  logic chk_en_lo = 1'b1, chk_en_hi = 1'b1, page_tagged = 1'b1;
  logic busy, done, pass, rd_en;
  logic [63:0] fault_addr;
  logic [TADDR_W-1:0] rd_addr;
  logic [7:0] rd_data;

  always #10 clk = ~clk;  // 50 MHz

  tagchk_top #(.SIZE_W(SIZE_W), .TADDR_W(TADDR_W)) u0 (.*);

  logic [7:0] tmem [256];
  always @(posedge clk) if (rd_en) rd_data <= tmem[rd_addr];

  int total = 0, bad = 0, rd_cnt = 0;
  logic [7:0] first_rd = '0;
  bit finished = 0;

  always @(posedge clk) begin
    if (start && !busy) rd_cnt = 0;
    else if (rd_en) begin
      if (rd_cnt == 0) first_rd = rd_addr;
      rd_cnt++;
    end
  end

  typedef struct {
    logic pass;
    logic [63:0] fault;
    logic noread;
    logic [7:0] faddr;
    string req;
  } item_t;
  item_t q[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pop and compare on every completion
  always @(negedge clk) begin
    if (rst_n && done && !finished) begin
      if (q.size() == 0) chk(0, "R10", 64'(done), 64'h0);
      else begin
        item_t e;
        e = q.pop_front();
        chk(pass == e.pass, e.req, 64'(pass), 64'(e.pass));
        chk(fault_addr == e.fault, e.req, fault_addr, e.fault);
        if (e.noread) chk(rd_cnt == 0, e.req, 64'(rd_cnt), 64'h0);
        else chk(first_rd == e.faddr, {e.req, " R4"}, 64'(first_rd), 64'(e.faddr));
      end
    end
  end

  function automatic logic [63:0] mk(input logic [3:0] key, input logic b55,
                                     input logic [23:0] a);
    return {4'h0, key, b55, 31'h0, a};
  endfunction

  function automatic item_t model(input logic [63:0] p, input logic [7:0] sz,
                                  input logic lo, input logic hi, input logic tg,
                                  input string req);
    item_t e;
    int cnt;
    e.req = req; e.pass = 1'b1; e.fault = p;
    e.noread = !(p[55] ? hi : lo) || !tg;
    e.faddr = p[12:5];
    if (e.noread) return e;
    cnt = ((int'(p[3:0]) + int'(sz)) >> 4) + 1;
    for (int g = 0; g < cnt; g++) begin
      logic [63:0] ga;
      logic [7:0] b;
      logic [3:0] nib;
      ga = {p[63:4], 4'h0} + 64'(16 * g);
      b = tmem[ga[12:5]];
      nib = ga[4] ? b[7:4] : b[3:0];
      if (nib != p[59:56]) begin
        e.pass = 1'b0;
        e.fault = (g == 0) ? p : ga;
        break;
      end
    end
    return e;
  endfunction

  task automatic send(input logic [63:0] p, input logic [7:0] sz, input logic lo,
                      input logic hi, input logic tg, input string req,
                      input bit intrude);
    q.push_back(model(p, sz, lo, hi, tg, req));
    start = 1; ptr = p; size_m1 = sz; chk_en_lo = lo; chk_en_hi = hi; page_tagged = tg;
    @(negedge clk);
    start = 0;
    if (intrude) begin
      @(negedge clk);
      start = 1; ptr = mk(4'h3, 1'b0, 24'h000100); page_tagged = 0;
      @(negedge clk);
      start = 0; page_tagged = 1;
    end
    while (!done) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) tmem[i] = 8'h77;
    tmem[8'h10] = 8'h37;  // granule 0x210 tag 3
    tmem[8'h12] = 8'h75;  // granule 0x240 tag 5
    tmem[8'h20] = 8'h97;  // granule 0x410 tag 9
    tmem[8'h58] = 8'h72;  // granule 0xB00 tag 2
    repeat (3) @(negedge clk);
    chk(!busy && !done && !pass && !rd_en && fault_addr == 0, "R1", fault_addr, 64'h0);
    rst_n = 1;
    @(negedge clk);
    send(mk(4'h7, 0, 24'h000100), 8'd63, 1, 1, 1, "R6", 0);
    send(mk(4'h7, 0, 24'h000110), 8'd31, 1, 1, 1, "R5", 0);
    send(mk(4'h7, 0, 24'h000214), 8'd3, 1, 1, 1, "R7", 0);
    send(mk(4'h7, 0, 24'h000228), 8'd40, 1, 1, 1, "R8", 0);
    send(mk(4'h7, 0, 24'h000400), 8'd31, 1, 1, 1, "R8 R5", 0);
    send(mk(4'h3, 0, 24'h000100), 8'd15, 0, 1, 1, "R2", 0);
    send(mk(4'h3, 1, 24'h000100), 8'd15, 0, 1, 1, "R2 R9", 0);
    send(mk(4'h3, 1, 24'h000100), 8'd15, 1, 0, 1, "R2", 0);
    send(mk(4'h3, 0, 24'h000100), 8'd15, 1, 1, 0, "R3", 0);
    send({4'hF, 4'h7, 56'h000000_00000300}, 8'd20, 1, 1, 1, "R9", 0);
    send(mk(4'h7, 0, 24'h00080F), 8'd255, 1, 1, 1, "R6 R11", 0);
    send(mk(4'h7, 0, 24'h000A0F), 8'd255, 1, 1, 1, "R8", 0);
    send(mk(4'h7, 0, 24'h00080F), 8'd255, 1, 1, 1, "R10", 1);
    repeat (4) @(negedge clk);
    chk(!done && pass == 1'b1, "R10", {63'h0, pass}, 64'h1);
    chk(fault_addr == mk(4'h7, 0, 24'h00080F), "R10", fault_addr, mk(4'h7, 0, 24'h00080F));
    send(mk(4'h7, 0, 24'h000214), 8'd0, 1, 1, 1, "R7", 0);
    repeat (4) @(negedge clk);
    chk(!pass && fault_addr == mk(4'h7, 0, 24'h000214), "R10", fault_addr,
        mk(4'h7, 0, 24'h000214));
    chk(q.size() == 0, "R10", 64'(q.size()), 64'h0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog R10 actual=%h expected=%h", 64'(busy), 64'h0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule